// File: doc/BRIEF.md
# Timed Sleep Controller with Chip-Select Wake

This block holds a device in a timed shutdown. Software writes a sleep length into the low byte of a 16-bit register; from the next clock the block raises its sleep output and counts down one unit per pulse of a slow half-second time-base tick. When the count runs out it clears the sleep output by itself. A low byte of zero starts a shutdown with no time limit.

Two things end a sleep early. The chip-select line, active low, can drop and then rise again while the device sleeps. A chip-select that only goes low does not end the sleep. The low level must be followed by a return high. Each end of sleep, by timeout or by chip-select, gives a single-cycle wake event. Chip-select is brought through a synchronizer of parameterized depth, so it may come straight from a pad.

Top module: `sleep_ctrl`

## Requirements
- R1: After synchronous reset the sleep output `sleep_o` and the wake event `wake_o` are both 0.
- R2: A write (`wr_en`=1) whose bits 7:0 hold N (1..255) sets `sleep_o` at the write's clock edge. The output stays 1 through the first N-1 clock edges that see `tick_half_s`=1 and falls at the edge of the Nth such tick. One tick is 0.5 s, so N=6 gives 3 s.
- R3: Bits 15:8 of the written word have no effect. The sleep length depends only on bits 7:0.
- R4: A written low byte of 0 starts an indefinite sleep. Ticks never end it.
- R5: While asleep, a falling and then a rising edge of `cs_n` ends the sleep. `sleep_o` falls at the (SYNC_STAGES+1)th clock edge after `cs_n` rises.
- R6: A low `cs_n` does not wake the device while it stays low. A `cs_n` pulse while awake has no effect. A `cs_n` fall seen before the sleep began does not count, so the rising edge that closes the write transfer does not wake.
- R7: `wake_o` is 1 for exactly one cycle, the cycle right after `sleep_o` falls, whether the sleep ended by timeout or by chip-select.
- R8: A write during sleep reloads the count with the new value and discards a pending `cs_n` fall. A write in the same cycle as an exit condition wins, and the device stays asleep.
- R9: While awake, ticks have no effect. `sleep_o` and `wake_o` stay 0 until a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_half_s | input | 1 | One-cycle half-second time-base pulse |
| wr_en | input | 1 | Sleep register write strobe |
| wr_data | input | REG_W | Written word; bits 7:0 carry the count |
| cs_n | input | 1 | Chip-select, active low, asynchronous |
| sleep_o | output | 1 | 1 while the device sleeps |
| wake_o | output | 1 | One-cycle pulse when sleep ends |

## Verification
A write and a tick each act at the clock edge that samples them. The bench drives them at a falling edge and checks `sleep_o` and `wake_o` at the very next falling edge. `cs_n` passes through SYNC_STAGES flops and an edge register, so its effect lands on the (SYNC_STAGES+1)th edge. The bench confirms the device is still asleep one sample before that edge and awake at it. Randomized runs use a reference model that counts ticks against the written low byte and may cut the run short with a chip-select pulse.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [1:0] {
    EXIT_NONE  = 2'd0,
    EXIT_TIMER = 2'd1,
    EXIT_CS    = 2'd2
  } exit_e;
endpackage

// File: rtl/slp_cs_edge.sv
module slp_cs_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_in,
  output logic cs_rise,
  output logic cs_fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b1;
        else     sync_q[0] <= cs_n_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[i] <= 1'b1;
        else     sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign cs_rise = sync_q[STAGES-1] & ~prev_q;
  assign cs_fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/slp_countdown.sv
module slp_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             tick,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             forever_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      forever_q <= 1'b0;
    end else if (load) begin
      cnt_q     <= load_val;
      forever_q <= (load_val == '0);
    end else if (run && tick && !forever_q) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign expire = run & tick & ~forever_q & (cnt_q == ONE);

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl #(
  parameter int REG_W       = 16,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_half_s,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             cs_n,
  output logic             sleep_o,
  output logic             wake_o
);
  import sleep_pkg::*;

  logic  cs_rise, cs_fall, expire;
  logic  sleep_q, wake_q, armed_q;
  exit_e exit_sel;

  slp_cs_edge #(.STAGES(SYNC_STAGES)) u_cs (
    .clk     (clk),
    .rst     (rst),
    .cs_n_in (cs_n),
    .cs_rise (cs_rise),
    .cs_fall (cs_fall)
  );

  slp_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_en),
    .load_val (wr_data[CNT_W-1:0]),
    .run      (sleep_q),
    .tick     (tick_half_s),
    .expire   (expire)
  );

  always_comb begin
    exit_sel = EXIT_NONE;
    if (sleep_q && !wr_en) begin
      if (expire)                exit_sel = EXIT_TIMER;
      else if (armed_q && cs_rise) exit_sel = EXIT_CS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_q <= 1'b0;
      wake_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      wake_q <= (exit_sel != EXIT_NONE);
      if (wr_en) begin
        sleep_q <= 1'b1;
        armed_q <= 1'b0;
      end else if (exit_sel != EXIT_NONE) begin
        sleep_q <= 1'b0;
        armed_q <= 1'b0;
      end else if (sleep_q && cs_fall) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign sleep_o = sleep_q;
  assign wake_o  = wake_q;

  // R2
  write_sleeps_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> sleep_o);
  // R7
  wake_single_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o |=> !wake_o);
  // R7
  wake_after_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (!sleep_o && $past(sleep_o)));
  // R9
  stay_awake_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep_o && !wr_en) |=> !sleep_o);
endmodule

// File: tb/test_sleep_ctrl.sv
module test_sleep_ctrl;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_half_s = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        cs_n = 1'b1;
  logic        sleep_o, wake_o;
  int          n_tests = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  sleep_ctrl #(.REG_W(16), .CNT_W(8), .SYNC_STAGES(SYNC)) i_sleep_ctrl (
    .clk(clk), .rst(rst), .tick_half_s(tick_half_s), .wr_en(wr_en),
    .wr_data(wr_data), .cs_n(cs_n), .sleep_o(sleep_o), .wake_o(wake_o)
  );

  function automatic logic model_sleep(int n, int done, logic cut);
    if (cut) return 1'b0;
    return (n == 0) || (done < n);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick_half_s = 1'b1;
    @(negedge clk); tick_half_s = 1'b0;
  endtask

  task automatic cs_pulse_wake(input string req);
    @(negedge clk); cs_n = 1'b0;
    repeat (SYNC + 2) @(negedge clk);
    cs_n = 1'b1;
    repeat (SYNC) @(negedge clk);
    check(sleep_o, 1, {req, " still asleep before sync delay"});
    @(negedge clk);
    check(sleep_o, 0, {req, " awake after cs rise"});
    check(wake_o, 1, "R7 wake pulse on cs exit");
    @(negedge clk);
    check(wake_o, 0, "R7 wake pulse one cycle");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(sleep_o, 0, "R1 sleep after reset");
    check(wake_o, 0, "R1 wake after reset");

    // R9: ticks while awake
    repeat (4) do_tick();
    check(sleep_o, 0, "R9 ticks while awake");
    check(wake_o, 0, "R9 no wake while awake");

    // R6: cs pulse while awake
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check(sleep_o, 0, "R6 cs pulse while awake");
    check(wake_o, 0, "R6 no wake pulse while awake");

    // R2: six ticks = 3 s
    do_write(16'h0006);
    check(sleep_o, 1, "R2 asleep after write");
    for (int i = 1; i <= 6; i++) begin
      repeat (2) @(negedge clk);
      do_tick();
      check(sleep_o, model_sleep(6, i, 1'b0), "R2 count of six");
      check(wake_o, (i == 6), "R7 timeout wake pulse");
    end
    @(negedge clk);
    check(wake_o, 0, "R7 timeout pulse one cycle");

    // R3: high byte ignored
    do_write(16'hFF02);
    do_tick();
    check(sleep_o, 1, "R3 high byte ignored, first tick");
    do_tick();
    check(sleep_o, 0, "R3 high byte ignored, second tick");

    // R4 / R5: indefinite sleep then cs wake
    do_write(16'hA500);
    repeat (20) do_tick();
    check(sleep_o, 1, "R4 indefinite sleep survives ticks");
    cs_pulse_wake("R5");

    // R6: long low level does not wake
    do_write(16'h0000);
    @(negedge clk); cs_n = 1'b0;
    repeat (12) @(negedge clk);
    check(sleep_o, 1, "R6 cs held low keeps sleep");
    cs_n = 1'b1;
    repeat (SYNC + 1) @(negedge clk);
    check(sleep_o, 0, "R6 cs return high wakes");
    @(negedge clk);

    // R6: cs fall before the write does not count
    @(negedge clk); cs_n = 1'b0;
    repeat (6) @(negedge clk);
    do_write(16'h0000);
    repeat (2) @(negedge clk); cs_n = 1'b1;
    repeat (8) @(negedge clk);
    check(sleep_o, 1, "R6 write-closing cs rise ignored");
    cs_pulse_wake("R6");

    // R8: reload during sleep
    do_write(16'h0005);
    repeat (3) do_tick();
    do_write(16'h0002);
    do_tick();
    check(sleep_o, 1, "R8 reload restarts count");
    do_tick();
    check(sleep_o, 0, "R8 reload expires on new count");

    // R8: write discards pending cs fall
    do_write(16'h0000);
    @(negedge clk); cs_n = 1'b0;
    repeat (5) @(negedge clk);
    do_write(16'h0000);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    check(sleep_o, 1, "R8 write clears pending cs fall");
    cs_pulse_wake("R8");

    // R8: write beats timeout in the same cycle
    do_write(16'h0001);
    @(negedge clk); tick_half_s = 1'b1; wr_en = 1'b1; wr_data = 16'h0001;
    @(negedge clk); tick_half_s = 1'b0; wr_en = 1'b0;
    check(sleep_o, 1, "R8 write wins over expiry");
    check(wake_o, 0, "R8 no wake when write wins");
    do_tick();
    check(sleep_o, 0, "R8 expiry after reload");

    // Random runs with reference model
    for (int it = 0; it < 40; it++) begin
      int n; int cut_at; logic [15:0] v;
      n = 1 + int'($urandom % 9);
      cut_at = ($urandom % 3 == 0) ? int'($urandom % n) : -1;
      v = {8'($urandom), 8'(n)};
      do_write(v);
      check(sleep_o, 1, "R2 random write sleeps");
      for (int d = 1; d <= n; d++) begin
        repeat ($urandom % 4) @(negedge clk);
        if (d - 1 == cut_at) begin
          cs_pulse_wake("R5 random");
          break;
        end
        do_tick();
        check(sleep_o, model_sleep(n, d, 1'b0), "R3 random count");
        check(wake_o, (d == n), "R7 random wake");
      end
      @(negedge clk);
      check(sleep_o, 0, "R9 random ends awake");
      check(wake_o, 0, "R7 random pulse cleared");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule